// File: doc/BRIEF.md
# UART FIFO Control with Trigger Thresholds

This block holds the transmit and receive byte queues of one UART channel together with the 8-bit control register that governs them. Each direction is a 32-entry first-in first-out store. An external shift register pushes received bytes in and pops bytes out for transmission. The host programs the control register through a simple write strobe, address and data bus. The serial logic, the baud generator and the interrupt logic sit outside this block.

Bit 0 of the control register switches the queues on or off. When the queues are off, each direction acts as a single-byte holding register. All other control bits are accepted only if the same write also sets bit 0.

Bits 1 and 2 empty the receive and transmit queues. They act at the edge that takes the write and need no clearing by the host. Bits 7:6 and 5:4 choose the receive and transmit thresholds, and each direction has a flag that shows its position relative to its threshold. Bit 3 is a legacy DMA-mode bit. The block stores it, and it drives nothing.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After synchronous reset, both levels are 0, the enable is 0, both overrun flags are 0, both pop data outputs are 0, rx_trig is 0 and tx_trig is 1.
- R2: A write to the control address sets fifo_en to reg_wdata bit 0 at that edge. Any write that changes the enable state empties both queues and clears both overrun flags at that same edge.
- R3: A control write with bit 0 equal to 0 leaves the threshold selections and the DMA bit unchanged and requests no per-direction emptying. A write to any other address changes nothing.
- R4: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue at that edge: level 0, overrun 0, and any push or pop in that cycle discarded (a pop in that cycle yields data 0). Bit 2 does the same for the transmit queue. Neither bit has any effect after that edge.
- R5: The DMA-mode bit (bit 3) is captured by an enabling write and changes no output.
- R6: Bits 7:6 select the receive threshold (00 = 8, 01 = 16, 10 = 24, 11 = 28). rx_trig is 1 while the receive level is at or above that threshold.
- R7: Bits 5:4 select the transmit threshold (00 = 16, 01 = 8, 10 = 24, 11 = 30). tx_trig is 1 while the transmit level is at or below that threshold.
- R8: With the queues enabled, each direction holds 32 bytes. A push into a full queue without a pop in the same cycle is dropped and sets that direction's sticky overrun flag.
- R9: A pop from a non-empty queue presents the oldest byte on the pop data output one cycle later. A pop from an empty queue gives 0 and leaves the level unchanged. The pop data output holds its value until the next pop.
- R10: A push and a pop in the same cycle on a full queue both succeed and leave the level unchanged.
- R11: With the queues disabled, each level is at most 1. A push into an occupied holding register is dropped and sets overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | 8 | Register write data |
| rx_push | input | 1 | Receive shift register delivers a byte |
| rx_push_data | input | DW (8) | Byte to store in the receive queue |
| rx_pop | input | 1 | Host-side read of the receive queue |
| rx_pop_data | output | DW (8) | Byte read from the receive queue |
| rx_level | output | LW (6) | Receive queue occupancy |
| rx_trig | output | 1 | Receive level at or above its threshold |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_push | input | 1 | Host writes a byte to transmit |
| tx_push_data | input | DW (8) | Byte to store in the transmit queue |
| tx_pop | input | 1 | Transmit shift register takes a byte |
| tx_pop_data | output | DW (8) | Byte read from the transmit queue |
| tx_level | output | LW (6) | Transmit queue occupancy |
| tx_trig | output | 1 | Transmit level at or below its threshold |
| tx_ovr | output | 1 | Sticky transmit overrun |
| fifo_en | output | 1 | Current queue enable state |

## Verification
An emptying request from the control register can arrive in the same cycle as a push and a pop on the queue it empties. The same holds for an enable toggle, which empties both queues. The bench provokes this on purpose by issuing bit-1 and bit-2 writes while pushing and popping the affected direction. A random phase then mixes control writes with traffic. A behavioural queue model decides each case by giving the emptying priority: the push is lost, the pop returns 0, and the overrun flag is cleared. The model is compared with every output on every clock.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       en;
  } fifo_cfg_t;

  // receive threshold: quarter, half, three quarters, depth minus 4
  function automatic int unsigned rx_thr(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return depth / 4;
      2'b01:   return depth / 2;
      2'b10:   return (3 * depth) / 4;
      default: return depth - 4;
    endcase
  endfunction

  // transmit threshold: half, quarter, three quarters, depth minus 2
  function automatic int unsigned tx_thr(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return depth / 2;
      2'b01:   return depth / 4;
      2'b10:   return (3 * depth) / 4;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // synchronous write and read, read-before-write on the same address
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import uart_fifo_pkg::*;
#(
  parameter int AW       = 3,
  parameter int CTL_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output fifo_cfg_t     cfg_q,
  output fifo_cfg_t     cfg_nxt,
  output logic          rx_clr,
  output logic          tx_clr
);

  logic hit;
  logic dma_q;
  logic dma_nxt;

  assign hit = we && (addr == AW'(CTL_ADDR));

  always_comb begin
    cfg_nxt = cfg_q;
    dma_nxt = dma_q;
    rx_clr  = 1'b0;
    tx_clr  = 1'b0;
    if (hit) begin
      if (wdata[0]) begin
        cfg_nxt.en     = 1'b1;
        cfg_nxt.rx_sel = wdata[7:6];
        cfg_nxt.tx_sel = wdata[5:4];
        dma_nxt        = wdata[3];
        rx_clr         = wdata[1] || !cfg_q.en;
        tx_clr         = wdata[2] || !cfg_q.en;
      end else begin
        cfg_nxt.en = 1'b0;
        rx_clr     = cfg_q.en;
        tx_clr     = cfg_q.en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      dma_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      dma_q <= dma_nxt;
    end
  end

  a_r2_en_follows: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cfg_q.en == $past(wdata[0])));

  a_r3_sel_kept: assert property (@(posedge clk) disable iff (rst)
    (hit && !wdata[0]) |=> ($stable(cfg_q.rx_sel) && $stable(cfg_q.tx_sel) && $stable(dma_q)));

  a_r3_other_addr: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> ($stable(cfg_q) && $stable(dma_q)));

  a_r5_dma_store: assert property (@(posedge clk) disable iff (rst)
    (hit && wdata[0]) |=> (dma_q == $past(wdata[3])));

endmodule

// File: rtl/fifo_chan.sv
module fifo_chan
  import uart_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter bit IS_RX = 1'b1,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    sel_nxt,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          trig,
  output logic          ovr
);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cap, lvl_nxt, thr_nxt;
  logic          pop_ok, push_ok, trig_nxt, vld_q;
  logic [DW-1:0] ram_q;

  assign cap     = en ? LW'(DEPTH) : LW'(1);
  assign pop_ok  = pop && (level != '0) && !clr;
  assign push_ok = push && !clr && ((level < cap) || pop_ok);

  always_comb begin
    if (clr)                    lvl_nxt = '0;
    else if (push_ok && !pop_ok) lvl_nxt = level + LW'(1);
    else if (pop_ok && !push_ok) lvl_nxt = level - LW'(1);
    else                        lvl_nxt = level;
  end

  generate
    if (IS_RX) begin : g_rx
      assign thr_nxt  = LW'(rx_thr(sel_nxt, DEPTH));
      assign trig_nxt = (lvl_nxt >= thr_nxt);
    end else begin : g_tx
      assign thr_nxt  = LW'(tx_thr(sel_nxt, DEPTH));
      assign trig_nxt = (lvl_nxt <= thr_nxt);
    end
  endgenerate

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
      vld_q  <= 1'b0;
      trig   <= !IS_RX;
    end else begin
      level <= lvl_nxt;
      trig  <= trig_nxt;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        ovr    <= 1'b0;
      end else begin
        if (push_ok) wr_ptr <= bump(wr_ptr);
        if (pop_ok)  rd_ptr <= bump(rd_ptr);
        if (push && !push_ok) ovr <= 1'b1;
      end
      if (pop) vld_q <= pop_ok;
    end
  end

  fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wr_ptr),
    .wdata (push_data),
    .re    (pop_ok),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  assign pop_data = vld_q ? ram_q : '0;

  a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  a_r4_clr_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0) && !ovr);

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr);

  a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && level == '0 && !push && !clr) |=> (level == '0) && (pop_data == '0));

  a_r10_full_swap: assert property (@(posedge clk) disable iff (rst)
    (en && level == LW'(DEPTH) && push && pop && !clr) |=> (level == LW'(DEPTH)) && !$rose(ovr));

  a_r11_hold_cap: assert property (@(posedge clk) disable iff (rst)
    !en |-> (level <= LW'(1)));

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 32,
  parameter int AW       = 3,
  parameter int CTL_ADDR = 2,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic [LW-1:0] rx_level,
  output logic          rx_trig,
  output logic          rx_ovr,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic [LW-1:0] tx_level,
  output logic          tx_trig,
  output logic          tx_ovr,
  output logic          fifo_en
);

  fifo_cfg_t cfg_q, cfg_nxt;
  logic      rx_clr, tx_clr;

  fifo_ctl_reg #(.AW(AW), .CTL_ADDR(CTL_ADDR)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cfg_q   (cfg_q),
    .cfg_nxt (cfg_nxt),
    .rx_clr  (rx_clr),
    .tx_clr  (tx_clr)
  );

  fifo_chan #(.DW(DW), .DEPTH(DEPTH), .IS_RX(1'b1)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_q.en),
    .sel_nxt   (cfg_nxt.rx_sel),
    .clr       (rx_clr),
    .push      (rx_push),
    .push_data (rx_push_data),
    .pop       (rx_pop),
    .pop_data  (rx_pop_data),
    .level     (rx_level),
    .trig      (rx_trig),
    .ovr       (rx_ovr)
  );

  fifo_chan #(.DW(DW), .DEPTH(DEPTH), .IS_RX(1'b0)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_q.en),
    .sel_nxt   (cfg_nxt.tx_sel),
    .clr       (tx_clr),
    .push      (tx_push),
    .push_data (tx_push_data),
    .pop       (tx_pop),
    .pop_data  (tx_pop_data),
    .level     (tx_level),
    .trig      (tx_trig),
    .ovr       (tx_ovr)
  );

  assign fifo_en = cfg_q.en;

endmodule

// File: tb/sim_uart_fifo_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_push_data = '0, tx_push_data = '0;
  logic [7:0] rx_pop_data, tx_pop_data;
  logic [5:0] rx_level, tx_level;
  logic       rx_trig, tx_trig, rx_ovr, tx_ovr, fifo_en;

  always #2 clk = ~clk;

  uart_fifo_ctl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .rx_level(rx_level), .rx_trig(rx_trig), .rx_ovr(rx_ovr),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
    .tx_pop_data(tx_pop_data), .tx_level(tx_level), .tx_trig(tx_trig), .tx_ovr(tx_ovr),
    .fifo_en(fifo_en)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  // reference model
  logic [7:0] rq[$];
  logic [7:0] tq[$];
  bit         m_en = 0, m_rovr = 0, m_tovr = 0;
  int         m_rsel = 0, m_tsel = 0;
  logic [7:0] m_rdat = 0, m_tdat = 0;
  int rx_t[4] = '{8, 16, 24, 28};
  int tx_t[4] = '{16, 8, 24, 30};

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", phase, what, act, exp, cycles);
    end
  endtask

  task automatic model_update();
    bit rclr = 0, tclr = 0, pok, sok;
    int cap;
    cap = m_en ? 32 : 1;
    if (rst) begin
      rq.delete(); tq.delete();
      m_en = 0; m_rovr = 0; m_tovr = 0; m_rsel = 0; m_tsel = 0; m_rdat = 0; m_tdat = 0;
      return;
    end
    if (reg_we && reg_addr == 3'd2) begin
      if (reg_wdata[0]) begin
        if (!m_en) begin rclr = 1; tclr = 1; end
        if (reg_wdata[1]) rclr = 1;
        if (reg_wdata[2]) tclr = 1;
        m_en = 1; m_rsel = reg_wdata[7:6]; m_tsel = reg_wdata[5:4];
      end else begin
        if (m_en) begin rclr = 1; tclr = 1; end
        m_en = 0;
      end
    end
    // receive direction
    if (rclr) begin
      rq.delete(); m_rovr = 0;
      if (rx_pop) m_rdat = 0;
    end else begin
      pok = rx_pop && rq.size() > 0;
      sok = rx_push && (rq.size() < cap || pok);
      if (rx_pop) m_rdat = pok ? rq[0] : 8'h00;
      if (pok) void'(rq.pop_front());
      if (sok) rq.push_back(rx_push_data);
      if (rx_push && !sok) m_rovr = 1;
    end
    // transmit direction
    if (tclr) begin
      tq.delete(); m_tovr = 0;
      if (tx_pop) m_tdat = 0;
    end else begin
      pok = tx_pop && tq.size() > 0;
      sok = tx_push && (tq.size() < cap || pok);
      if (tx_pop) m_tdat = pok ? tq[0] : 8'h00;
      if (pok) void'(tq.pop_front());
      if (sok) tq.push_back(tx_push_data);
      if (tx_push && !sok) m_tovr = 1;
    end
  endtask

  task automatic compare();
    chk("fifo_en (R2)",      fifo_en, m_en);
    chk("rx_level (R8)",     rx_level, rq.size());
    chk("tx_level (R8)",     tx_level, tq.size());
    chk("rx_trig (R6)",      rx_trig, (rq.size() >= rx_t[m_rsel]) ? 1 : 0);
    chk("tx_trig (R7)",      tx_trig, (tq.size() <= tx_t[m_tsel]) ? 1 : 0);
    chk("rx_ovr (R8)",       rx_ovr, m_rovr);
    chk("tx_ovr (R8)",       tx_ovr, m_tovr);
    chk("rx_pop_data (R9)",  rx_pop_data, m_rdat);
    chk("tx_pop_data (R9)",  tx_pop_data, m_tdat);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    cycles++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    reg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic push_both(input int n);
    for (int i = 0; i < n; i++) begin
      rx_push = 1; rx_push_data = 8'(8'h10 + i);
      tx_push = 1; tx_push_data = 8'(8'hA0 + i);
      step();
    end
    rx_push = 0; tx_push = 0;
  endtask

  task automatic pop_both(input int n);
    for (int i = 0; i < n; i++) begin
      rx_pop = 1; tx_pop = 1;
      step();
    end
    rx_pop = 0; tx_pop = 0;
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    step(); step();
    rst = 0;
    phase = "R1";
    step();

    phase = "R2"; wr(3'd2, 8'h01);
    phase = "R6"; push_both(10);
    for (int s = 0; s < 4; s++) begin
      phase = "R7";
      wr(3'd2, 8'(s * 64 + s * 16 + 1));
      push_both(8);
    end
    phase = "R8"; push_both(6);
    phase = "R10";
    rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1; rx_push_data = 8'h5A; tx_push_data = 8'hC3;
    step(); step();
    idle();
    phase = "R9"; pop_both(34);
    phase = "R4"; push_both(5);
    rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1;
    wr(3'd2, 8'h03);
    step(); idle();
    rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1;
    wr(3'd2, 8'h05);
    idle(); push_both(3); step();
    phase = "R3"; wr(3'd5, 8'hFE); step();
    wr(3'd2, 8'hF6); step();
    phase = "R11"; push_both(3); pop_both(2);
    rx_push = 1; rx_pop = 1; tx_push = 1; tx_pop = 1; step(); idle();
    phase = "R5"; wr(3'd2, 8'h09); push_both(4); wr(3'd2, 8'h01); pop_both(2);
    phase = "R3"; wr(3'd2, 8'h30); wr(3'd2, 8'hC1); push_both(30);

    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      rx_push = 1'($urandom_range(0, 1)); rx_push_data = 8'($urandom);
      tx_push = 1'($urandom_range(0, 1)); tx_push_data = 8'($urandom);
      rx_pop  = ($urandom_range(0, 2) == 0);
      tx_pop  = ($urandom_range(0, 2) == 0);
      reg_we  = ($urandom_range(0, 40) == 0);
      reg_addr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd2;
      reg_wdata = ($urandom_range(0, 7) == 0) ? 8'($urandom) & 8'hFE : 8'($urandom) | 8'h01;
      step();
    end
    idle(); step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule